// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small logic array with two programmable planes. It evaluates a set of sum-of-products functions over a few input signals. Each product term has its own stored code for every input: the input takes part true, takes part inverted, or is left out. Each product term also has a connection mask that routes it to any subset of the outputs. Because a term can be routed to several outputs, one term is built once and then shared by every function that needs it.

Software-free configuration happens through a write port. Each write names a term index and supplies three things for that term: its AND-plane code, given as a use mask and a polarity mask, and its OR-plane mask. The write is captured on a rising clock edge. Outside of writes, the path from the data inputs to the outputs is purely combinational. A synchronous reset disconnects every term, so every output reads 0 until terms are loaded.

With the default sizes, the array has 3 inputs, 4 outputs and 7 product terms. That is enough for the four-function set F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A, which needs five distinct terms.

Top module: `pla_fabric`

## Requirements
- R1: While `rst` is high at a rising edge, every stored term is cleared: all use bits, polarity bits and connection bits go to 0. After that edge and until a valid write, `dataOut` is 0 for every input value.
- R2: For term t and input i, `cfgUse[i]`=1 with `cfgPol[i]`=1 means input i is used true. `cfgUse[i]`=1 with `cfgPol[i]`=0 means input i is used inverted. `cfgUse[i]`=0 means input i is absent and its literal reads 1. Bit i of `cfgUse` and `cfgPol` refers to `dataIn[i]`.
- R3: A term whose use mask is all zero evaluates to 1 for every input value.
- R4: Bit j of `cfgOrMask` connects the term to `dataOut[j]`. Each output is the OR of the terms connected to it. An output with no connected term reads 0.
- R5: One term with several bits set in its connection mask drives all of those outputs at the same time.
- R6: When `cfgWrEn` is high at a rising edge, the term named by `cfgTermIdx` is loaded. The new code shows on `dataOut` only after that edge. Other terms keep their contents, and no change occurs when `cfgWrEn` is low.
- R7: A write whose `cfgTermIdx` is N_TERM or above changes no stored term.
- R8: After the five-term default program is loaded, `dataOut[3:0]` equals {B'C + A, B'C' + AB, AC' + AB, A + B'C'} for all 8 input values. Here A = `dataIn[2]`, B = `dataIn[1]` and C = `dataIn[0]`.
- R9: Rewriting a term fully replaces its earlier code and mask, so the array can be loaded with a new function set.
- R10: `dataOut` follows a change on `dataIn` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; configuration writes are captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset that disconnects all terms |
| cfgWrEn | input | 1 | Write strobe for one product term |
| cfgTermIdx | input | TIDX_W (3) | Index of the term being written |
| cfgUse | input | N_IN (3) | Per-input participation bits for the term |
| cfgPol | input | N_IN (3) | Per-input polarity bits (1 = true, 0 = inverted) |
| cfgOrMask | input | N_OUT (4) | Outputs the term is connected to |
| dataIn | input | N_IN (3) | Logic inputs to the array |
| dataOut | output | N_OUT (4) | Sum-of-products results |

## Verification
The stability properties assume that `dataIn` changes only when it is meant to. They claim nothing for a cycle in which the inputs move, because a changed input can legally change the outputs. The bench drives `dataIn` and every configuration field at the falling edge. It holds `dataIn` still across each edge that follows a write, so the no-effect and no-write checks always compare matching input values. The reset property assumes that only an in-range write can make an output rise. The bench confirms this at the ports by sweeping all input values after out-of-range writes.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // Strobes handed from the control decoder to the datapath.
  typedef struct packed {
    logic clearAll;   // wipe every term (synchronous reset)
    logic writeOk;    // load the addressed term this edge
  } plaStrobe_t;

  // One literal of a product term: absent literals pass, present ones
  // pass when the input matches the stored polarity.
  function automatic logic litPass(input logic useBit,
                                   input logic polBit,
                                   input logic x);
    return (!useBit) || (x == polBit);
  endfunction

endpackage

// File: rtl/pla_ctrl.sv
`timescale 1ns/1ps
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int N_TERM = 7,
  parameter int TIDX_W = 3
) (
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [TIDX_W-1:0] cfgTermIdx,
  output plaStrobe_t        strb
);

  localparam logic [TIDX_W:0] TERM_LIMIT = (TIDX_W+1)'(N_TERM);

  logic idxInRange;

  // Indices at or beyond the term count are dropped here (R7).
  assign idxInRange = ({1'b0, cfgTermIdx} < TERM_LIMIT);

  always_comb begin
    strb          = '0;
    strb.clearAll = rst;
    strb.writeOk  = cfgWrEn && !rst && idxInRange;
  end

endmodule

// File: rtl/pla_datapath.sv
`timescale 1ns/1ps
module pla_datapath
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 7,
  parameter int TIDX_W = 3
) (
  input  logic              clk,
  input  plaStrobe_t        strb,
  input  logic [TIDX_W-1:0] termIdx,
  input  logic [N_IN-1:0]   useIn,
  input  logic [N_IN-1:0]   polIn,
  input  logic [N_OUT-1:0]  maskIn,
  input  logic [N_IN-1:0]   dataIn,
  output logic [N_TERM-1:0] termHit,
  output logic [N_OUT-1:0]  dataOut
);

  localparam int OR_BITS = N_TERM * N_OUT;

  logic [OR_BITS-1:0] orFlat;

  // AND plane: one storage slice and one product per term.
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0]  useQ;
    logic [N_IN-1:0]  polQ;
    logic [N_OUT-1:0] orQ;
    logic [N_IN-1:0]  litOk;
    logic             selThis;

    assign selThis = strb.writeOk && (termIdx == TIDX_W'(t));

    always_ff @(posedge clk) begin
      if (strb.clearAll) begin
        useQ <= '0;
        polQ <= '0;
        orQ  <= '0;
      end else if (selThis) begin
        useQ <= useIn;
        polQ <= polIn;
        orQ  <= maskIn;
      end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign litOk[i] = litPass(useQ[i], polQ[i], dataIn[i]);
    end

    assign termHit[t]                  = &litOk;
    assign orFlat[t*N_OUT +: N_OUT]    = orQ;
  end

  // OR plane: gather each output's column of connection bits.
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] colMask;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign colMask[t] = orFlat[t*N_OUT + j];
    end
    assign dataOut[j] = |(colMask & termHit);
  end

endmodule

// File: rtl/pla_fabric.sv
`timescale 1ns/1ps
module pla_fabric
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 7,
  parameter int TIDX_W = (N_TERM > 1) ? $clog2(N_TERM + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [TIDX_W-1:0] cfgTermIdx,
  input  logic [N_IN-1:0]   cfgUse,
  input  logic [N_IN-1:0]   cfgPol,
  input  logic [N_OUT-1:0]  cfgOrMask,
  input  logic [N_IN-1:0]   dataIn,
  output logic [N_OUT-1:0]  dataOut
);

  plaStrobe_t        strb;
  logic [N_TERM-1:0] termHit;

  pla_ctrl #(
    .N_TERM (N_TERM),
    .TIDX_W (TIDX_W)
  ) u_ctrl (
    .rst        (rst),
    .cfgWrEn    (cfgWrEn),
    .cfgTermIdx (cfgTermIdx),
    .strb       (strb)
  );

  pla_datapath #(
    .N_IN   (N_IN),
    .N_OUT  (N_OUT),
    .N_TERM (N_TERM),
    .TIDX_W (TIDX_W)
  ) u_dp (
    .clk     (clk),
    .strb    (strb),
    .termIdx (cfgTermIdx),
    .useIn   (cfgUse),
    .polIn   (cfgPol),
    .maskIn  (cfgOrMask),
    .dataIn  (dataIn),
    .termHit (termHit),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/pla_fabric_chk.sv
`timescale 1ns/1ps
module pla_fabric_chk #(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 7,
  parameter int TIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgWrEn,
  input logic [TIDX_W-1:0] cfgTermIdx,
  input logic [N_IN-1:0]   dataIn,
  input logic [N_OUT-1:0]  dataOut,
  input logic [N_TERM-1:0] termHit
);

  logic idxBad;
  logic wroteSinceRst;

  assign idxBad = ({1'b0, cfgTermIdx} >= (TIDX_W+1)'(N_TERM));

  always_ff @(posedge clk) begin
    if (rst)                     wroteSinceRst <= 1'b0;
    else if (cfgWrEn && !idxBad) wroteSinceRst <= 1'b1;
  end

  // R1: nothing is connected until a valid write follows reset
  a_r1_cleared_until_write: assert property (@(posedge clk) disable iff (rst)
    !wroteSinceRst |-> (dataOut == '0));

  // R4: with no product term active, no output can be high
  a_r4_no_term_no_output: assert property (@(posedge clk) disable iff (rst)
    (termHit == '0) |-> (dataOut == '0));

  // R6: without a write, outputs only move when the inputs move
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !cfgWrEn |=> ($stable(dataIn) -> $stable(dataOut)));

  // R7: an out-of-range write leaves the function unchanged
  a_r7_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && idxBad) |=> ($stable(dataIn) -> $stable(dataOut)));

endmodule

bind pla_fabric pla_fabric_chk #(
  .N_IN   (N_IN),
  .N_OUT  (N_OUT),
  .N_TERM (N_TERM),
  .TIDX_W (TIDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfgWrEn    (cfgWrEn),
  .cfgTermIdx (cfgTermIdx),
  .dataIn     (dataIn),
  .dataOut    (dataOut),
  .termHit    (termHit)
);

// File: tb/pla_fabric_bench.sv
`timescale 1ns/1ps
module pla_fabric_bench;

  localparam int N_IN = 3, N_OUT = 4, N_TERM = 7, TIDX_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfgWrEn = 1'b0;
  logic [TIDX_W-1:0] cfgTermIdx = '0;
  logic [N_IN-1:0]   cfgUse = '0;
  logic [N_IN-1:0]   cfgPol = '0;
  logic [N_OUT-1:0]  cfgOrMask = '0;
  logic [N_IN-1:0]   dataIn = '0;
  logic [N_OUT-1:0]  dataOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pla_fabric u_pla_fabric (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgTermIdx(cfgTermIdx),
    .cfgUse(cfgUse), .cfgPol(cfgPol), .cfgOrMask(cfgOrMask),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  task automatic chk(input string req, input logic [N_OUT-1:0] act,
                     input logic [N_OUT-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: dataIn=%b actual=%b expected=%b", req, dataIn, act, exp);
    end
  endtask

  // A=dataIn[2], B=dataIn[1], C=dataIn[0]
  function automatic logic [3:0] modelDefault(input logic [2:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
  endfunction

  function automatic logic [3:0] modelSecond(input logic [2:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {1'b0, a & b & c, ~a & ~b & ~c, a ^ b ^ c};
  endfunction

  task automatic writeTerm(input int idx, input logic [2:0] u,
                           input logic [2:0] p, input logic [3:0] m);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTermIdx = TIDX_W'(idx);
    cfgUse = u; cfgPol = p; cfgOrMask = m;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: after reset every input value gives all-zero outputs
  task automatic testReset(input string tag);
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk(tag, dataOut, 4'b0000);
    end
  endtask

  // R3, R6: all-absent term, visible only after the capturing edge
  task automatic testAbsentTerm();
    dataIn = 3'b101;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgTermIdx = 3'd6; cfgUse = 3'b000; cfgPol = 3'b111;
    cfgOrMask = 4'b0001;
    #1 chk("R6 before edge", dataOut, 4'b0000);
    @(negedge clk); cfgWrEn = 1'b0;
    #1 chk("R6 after edge", dataOut, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk("R3 all-absent term", dataOut, 4'b0001);
    end
    // R2: single true literal on input 1 only
    writeTerm(6, 3'b010, 3'b010, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk("R2 true literal", dataOut, {3'b000, dataIn[1]});
    end
    // R2: inverted literal on input 0
    writeTerm(6, 3'b001, 3'b000, 4'b0001);
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk("R2 inverted literal", dataOut, {3'b000, ~dataIn[0]});
    end
    writeTerm(6, 3'b000, 3'b000, 4'b0000);
  endtask

  // R8, R5, R10: default function set with shared terms
  task automatic testDefault();
    writeTerm(0, 3'b110, 3'b110, 4'b0110); // AB   -> F1,F2 (R5 shared)
    writeTerm(1, 3'b011, 3'b001, 4'b1000); // B'C  -> F3
    writeTerm(2, 3'b101, 3'b100, 4'b0010); // AC'  -> F1
    writeTerm(3, 3'b011, 3'b000, 4'b0101); // B'C' -> F0,F2 (R5 shared)
    writeTerm(4, 3'b100, 3'b100, 4'b1001); // A    -> F0,F3
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;   // R10: no clock edge between change and sample
      chk("R8 default set", dataOut, modelDefault(3'(v)));
    end
    dataIn = 3'b110; #1;
    chk("R5 shared AB drives F1 and F2", dataOut & 4'b0110, 4'b0110);
  endtask

  // R7: index beyond the term count has no effect
  task automatic testBadIndex();
    writeTerm(7, 3'b000, 3'b000, 4'b1111);
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk("R7 bad index ignored", dataOut, modelDefault(3'(v)));
    end
  endtask

  // R9, R4: reprogram with a second set; output 3 left unconnected
  task automatic testReprogram();
    writeTerm(0, 3'b111, 3'b100, 4'b0001); // AB'C'
    writeTerm(1, 3'b111, 3'b010, 4'b0001); // A'BC'
    writeTerm(2, 3'b111, 3'b001, 4'b0001); // A'B'C
    writeTerm(3, 3'b111, 3'b111, 4'b0101); // ABC -> G0, G2
    writeTerm(4, 3'b111, 3'b000, 4'b0010); // A'B'C'
    for (int v = 0; v < 8; v++) begin
      dataIn = 3'(v); #1;
      chk("R9 second set", dataOut, modelSecond(3'(v)));
      chk("R4 unconnected output", {3'b000, dataOut[3]}, 4'b0000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset("R1 reset state");
    testAbsentTerm();
    testDefault();
    testBadIndex();
    testReprogram();
    doReset();
    testReset("R1 reset after programming");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule